// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block computes and commits the architectural state change a processor makes when it leaves normal execution for a handler. Five causes can ask for entry: a memory-management exception, a hardware exception, a hardware break, a software break and an external interrupt. The execution pipeline presents the current program counter, the machine status word, the exception status word, the pending branch target and the delay-slot, immediate-prefix and prefixed-branch flags, together with a vector base. When a take strobe is raised, the sequencer selects one cause and registers the following results in a single clock:
- the new program counter;
- the updated status words;
- the branch-target register load;
- the cleared pipeline flags;
- a link-register write, given as a register index and a value.

The return address saved for a memory-management exception is wound back so that an interrupted prefix or branch is executed again. On every entry the mode bits are saved into their shadow bits and then cleared. A combinational acceptance signal tells the pipeline whether an external interrupt may be taken in the current state. A one-hot acknowledge pulse reports which cause was serviced.

Top module: `exc_entry_seq`

## Requirements
- R1: The request vector uses bit 0 for a memory-management exception, bit 1 for a hardware exception, bit 2 for a hardware break, bit 3 for a software break and bit 4 for an interrupt. The lowest-numbered eligible bit wins. The cycle after a take, `ack_o` is one-hot on the winner, and it is zero in every other cycle.
- R2: `irq_ok_o` is high only when the interrupt-enable bit (status bit 1) is set, exception-in-progress (bit 9) and break-in-progress (bit 3) are both clear, and both the delay-slot and the immediate-prefix flags are clear. Request bit 4 is eligible only while `irq_ok_o` is high.
- R3: The new PC is the vector base plus 0x10 for an interrupt, plus 0x18 for a hardware break, and plus 0x20 for either exception. A software break loads the pending branch target.
- R4: Link writes go to register 14 with the PC for an interrupt, to register 16 with the PC for a hardware break, and to register 17 for exceptions. The value is PC+4 for a hardware exception and the PC for a memory-management exception. A software break makes no link write.
- R5: For a memory-management exception, the link value is PC-4 in a delay slot and PC-8 in a delay slot whose branch was prefixed. Outside a delay slot it is PC-4 when the immediate-prefix flag is set.
- R6: Both exception kinds set exception-status bit 12 equal to the delay-slot flag. When that flag is set, they also load the branch-target output with the pending target and pulse `btr_we_o`. Other causes leave the exception status unchanged.
- R7: On every entry, the new status word has the old virtual-mode bit 13 in bit 14 and the old user-mode bit 11 in bit 12, and bits 13 and 11 are cleared.
- R8: Exceptions set status bit 9, breaks set status bit 3, and an interrupt clears status bit 1. All other status bits pass through unchanged.
- R9: When `exc_en_i` is low, request bit 1 is ignored and the next eligible cause is taken.
- R10: Exception entry clears the delay-slot and immediate-prefix outputs, while breaks pass the flags through. Every entry pulses `resv_clr_o`.
- R11: After reset, all outputs are zero. A cycle without a take, or a take with no eligible cause, leaves the held outputs unchanged and pulses nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Commit strobe |
| req_i | input | 5 | Cause requests (R1 bit order) |
| exc_en_i | input | 1 | Hardware-exception support enabled |
| pc_i | input | 32 | Current PC |
| msr_i | input | 32 | Current machine status word |
| esr_i | input | 32 | Current exception status word |
| btarget_i | input | 32 | Pending branch target |
| dslot_i | input | 1 | In delay slot |
| imm_i | input | 1 | Immediate prefix pending |
| bimm_i | input | 1 | Branch carried a prefix |
| vec_base_i | input | 32 | Vector base address |
| irq_ok_o | output | 1 | Interrupt may be accepted |
| ack_o | output | 5 | One-hot taken cause pulse |
| pc_o | output | 32 | New PC |
| msr_o | output | 32 | New status word |
| esr_o | output | 32 | New exception status word |
| btr_o | output | 32 | Branch-target register value |
| btr_we_o | output | 1 | Branch-target load pulse |
| link_we_o | output | 1 | Link write pulse |
| link_idx_o | output | 5 | Link register index |
| link_val_o | output | 32 | Link value |
| dslot_o | output | 1 | New delay-slot flag |
| imm_o | output | 1 | New immediate-prefix flag |
| resv_clr_o | output | 1 | Invalidate load reservation pulse |

## Verification
A wrong arbitration or gating decision shows up in the cycle right after the take: `ack_o` names the wrong cause, or it fires when it should stay silent, and `pc_o` then points at the wrong vector. Faulty rewind arithmetic is confined to `link_val_o`, so it appears in that same cycle only for memory-management entries that carry delay-slot or prefix state. For this reason the vectors cover each flag combination separately. A mis-wired mode-bit save does not disturb the program counter, and it can be seen only by comparing `msr_o` after an entry from a status word with the mode bits set.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int NCAUSE = 5;
  localparam int C_MMU  = 0;
  localparam int C_HWX  = 1;
  localparam int C_HBRK = 2;
  localparam int C_SBRK = 3;
  localparam int C_IRQ  = 4;

  localparam int ST_IE  = 1;
  localparam int ST_BIP = 3;
  localparam int ST_EIP = 9;
  localparam int ST_UM  = 11;
  localparam int ST_UMS = 12;
  localparam int ST_VM  = 13;
  localparam int ST_VMS = 14;
  localparam int ES_DS  = 12;

  localparam int OFS_IRQ  = 'h10;
  localparam int OFS_HBRK = 'h18;
  localparam int OFS_EXC  = 'h20;

  localparam int LNK_IRQ  = 14;
  localparam int LNK_HBRK = 16;
  localparam int LNK_EXC  = 17;
endpackage

// File: rtl/exc_irq_gate.sv
module exc_irq_gate
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] msr_i,
  input  logic            dslot_i,
  input  logic            imm_i,
  output logic            irq_ok_o
);
  logic busy;
  assign busy     = msr_i[ST_EIP] | msr_i[ST_BIP] | dslot_i | imm_i;
  assign irq_ok_o = msr_i[ST_IE] & ~busy;
endmodule

// File: rtl/exc_cause_arb.sv
module exc_cause_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig_i,
  output logic [N-1:0] win_o
);
  // lowest index has highest priority
  assign win_o = elig_i & (~elig_i + N'(1));
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic [NCAUSE-1:0] win_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   esr_i,
  input  logic [XLEN-1:0]   btarget_i,
  input  logic              dslot_i,
  input  logic              imm_i,
  input  logic              bimm_i,
  input  logic [XLEN-1:0]   vec_base_i,
  output logic [XLEN-1:0]   nxt_pc_o,
  output logic [XLEN-1:0]   nxt_msr_o,
  output logic [XLEN-1:0]   nxt_esr_o,
  output logic              btr_load_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              nxt_dslot_o,
  output logic              nxt_imm_o
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  function automatic logic [XLEN-1:0] f_mode_save(input logic [XLEN-1:0] s);
    logic [XLEN-1:0] r;
    r = s;
    r[ST_VMS] = s[ST_VM];
    r[ST_UMS] = s[ST_UM];
    r[ST_VM]  = 1'b0;
    r[ST_UM]  = 1'b0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] f_mmu_link(input logic [XLEN-1:0] pc,
                                                  input logic ds, input logic im,
                                                  input logic bi);
    logic [XLEN-1:0] r;
    r = pc;
    if (ds) begin
      r = r - STEP;
      if (bi) r = r - STEP;
    end else if (im) begin
      r = r - STEP;
    end
    return r;
  endfunction

  logic [XLEN-1:0] saved;
  logic            is_exc;
  assign saved  = f_mode_save(msr_i);
  assign is_exc = win_i[C_MMU] | win_i[C_HWX];

  always_comb begin
    nxt_pc_o    = pc_i;
    nxt_msr_o   = msr_i;
    nxt_esr_o   = esr_i;
    btr_load_o  = 1'b0;
    link_we_o   = 1'b0;
    link_idx_o  = '0;
    link_val_o  = '0;
    nxt_dslot_o = dslot_i;
    nxt_imm_o   = imm_i;
    if (is_exc) begin
      nxt_pc_o          = vec_base_i + XLEN'(OFS_EXC);
      nxt_msr_o         = saved;
      nxt_msr_o[ST_EIP] = 1'b1;
      nxt_esr_o[ES_DS]  = dslot_i;
      btr_load_o        = dslot_i;
      link_we_o         = 1'b1;
      link_idx_o        = RIDX_W'(LNK_EXC);
      link_val_o        = win_i[C_MMU] ? f_mmu_link(pc_i, dslot_i, imm_i, bimm_i)
                                       : pc_i + STEP;
      nxt_dslot_o       = 1'b0;
      nxt_imm_o         = 1'b0;
    end else if (win_i[C_HBRK]) begin
      nxt_pc_o          = vec_base_i + XLEN'(OFS_HBRK);
      nxt_msr_o         = saved;
      nxt_msr_o[ST_BIP] = 1'b1;
      link_we_o         = 1'b1;
      link_idx_o        = RIDX_W'(LNK_HBRK);
      link_val_o        = pc_i;
    end else if (win_i[C_SBRK]) begin
      nxt_pc_o          = btarget_i;
      nxt_msr_o         = saved;
      nxt_msr_o[ST_BIP] = 1'b1;
    end else if (win_i[C_IRQ]) begin
      nxt_pc_o          = vec_base_i + XLEN'(OFS_IRQ);
      nxt_msr_o         = saved;
      nxt_msr_o[ST_IE]  = 1'b0;
      link_we_o         = 1'b1;
      link_idx_o        = RIDX_W'(LNK_IRQ);
      link_val_o        = pc_i;
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [NCAUSE-1:0] req_i,
  input  logic              exc_en_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   msr_i,
  input  logic [XLEN-1:0]   esr_i,
  input  logic [XLEN-1:0]   btarget_i,
  input  logic              dslot_i,
  input  logic              imm_i,
  input  logic              bimm_i,
  input  logic [XLEN-1:0]   vec_base_i,
  output logic              irq_ok_o,
  output logic [NCAUSE-1:0] ack_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   esr_o,
  output logic [XLEN-1:0]   btr_o,
  output logic              btr_we_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              dslot_o,
  output logic              imm_o,
  output logic              resv_clr_o
);
  logic [NCAUSE-1:0] elig, win;
  logic              commit;
  logic [XLEN-1:0]   c_pc, c_msr, c_esr, c_lval;
  logic              c_btr, c_lwe, c_ds, c_im;
  logic [RIDX_W-1:0] c_lidx;

  exc_irq_gate #(.XLEN(XLEN)) u_gate (
    .msr_i(msr_i), .dslot_i(dslot_i), .imm_i(imm_i), .irq_ok_o(irq_ok_o)
  );

  always_comb begin
    elig        = req_i;
    elig[C_IRQ] = req_i[C_IRQ] & irq_ok_o;
    elig[C_HWX] = req_i[C_HWX] & exc_en_i;
  end

  exc_cause_arb #(.N(NCAUSE)) u_arb (.elig_i(elig), .win_o(win));

  assign commit = take_i & (|win);

  exc_state_calc #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_calc (
    .win_i(win), .pc_i(pc_i), .msr_i(msr_i), .esr_i(esr_i),
    .btarget_i(btarget_i), .dslot_i(dslot_i), .imm_i(imm_i), .bimm_i(bimm_i),
    .vec_base_i(vec_base_i), .nxt_pc_o(c_pc), .nxt_msr_o(c_msr),
    .nxt_esr_o(c_esr), .btr_load_o(c_btr), .link_we_o(c_lwe),
    .link_idx_o(c_lidx), .link_val_o(c_lval), .nxt_dslot_o(c_ds),
    .nxt_imm_o(c_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_o      <= '0;
      pc_o       <= '0;
      msr_o      <= '0;
      esr_o      <= '0;
      btr_o      <= '0;
      btr_we_o   <= 1'b0;
      link_we_o  <= 1'b0;
      link_idx_o <= '0;
      link_val_o <= '0;
      dslot_o    <= 1'b0;
      imm_o      <= 1'b0;
      resv_clr_o <= 1'b0;
    end else begin
      ack_o      <= commit ? win : '0;
      btr_we_o   <= commit & c_btr;
      link_we_o  <= commit & c_lwe;
      resv_clr_o <= commit;
      if (commit) begin
        pc_o    <= c_pc;
        msr_o   <= c_msr;
        esr_o   <= c_esr;
        dslot_o <= c_ds;
        imm_o   <= c_im;
        if (c_btr) btr_o <= btarget_i;
        if (c_lwe) begin
          link_idx_o <= c_lidx;
          link_val_o <= c_lval;
        end
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              take_i,
  input logic              exc_en_i,
  input logic [XLEN-1:0]   vec_base_i,
  input logic              irq_ok_o,
  input logic [NCAUSE-1:0] ack_o,
  input logic [XLEN-1:0]   pc_o,
  input logic [XLEN-1:0]   msr_o,
  input logic              link_we_o,
  input logic [RIDX_W-1:0] link_idx_o,
  input logic              dslot_o,
  input logic              imm_o
);
  p_ack_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o));
  p_ack_needs_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_o) |-> $past(take_i));
  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[C_IRQ] |-> $past(irq_ok_o));
  p_hwx_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[C_HWX] |-> $past(exc_en_i));
  p_exc_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o[C_MMU] | ack_o[C_HWX]) |-> (msr_o[ST_EIP] && !msr_o[ST_VM] && !msr_o[ST_UM]));
  p_irq_link_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[C_IRQ] |-> (link_we_o && link_idx_o == RIDX_W'(LNK_IRQ)));
  p_hbrk_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[C_HBRK] |-> (pc_o == $past(vec_base_i) + XLEN'(OFS_HBRK)));
  p_exc_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o[C_MMU] | ack_o[C_HWX]) |-> (!dslot_o && !imm_o));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_i(take_i), .exc_en_i(exc_en_i),
  .vec_base_i(vec_base_i), .irq_ok_o(irq_ok_o), .ack_o(ack_o), .pc_o(pc_o),
  .msr_o(msr_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o),
  .dslot_o(dslot_o), .imm_o(imm_o)
);

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic [4:0]  req_i = '0;
  logic        exc_en_i = 1'b1;
  logic [31:0] pc_i = 32'h1000, msr_i = '0, esr_i = '0;
  logic [31:0] btarget_i = 32'h2000, vec_base_i = 32'h8000;
  logic        dslot_i = 1'b0, imm_i = 1'b0, bimm_i = 1'b0;
  logic        irq_ok_o, btr_we_o, link_we_o, dslot_o, imm_o, resv_clr_o;
  logic [4:0]  ack_o, link_idx_o;
  logic [31:0] pc_o, msr_o, esr_o, btr_o, link_val_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .req_i(req_i),
    .exc_en_i(exc_en_i), .pc_i(pc_i), .msr_i(msr_i), .esr_i(esr_i),
    .btarget_i(btarget_i), .dslot_i(dslot_i), .imm_i(imm_i), .bimm_i(bimm_i),
    .vec_base_i(vec_base_i), .irq_ok_o(irq_ok_o), .ack_o(ack_o), .pc_o(pc_o),
    .msr_o(msr_o), .esr_o(esr_o), .btr_o(btr_o), .btr_we_o(btr_we_o),
    .link_we_o(link_we_o), .link_idx_o(link_idx_o), .link_val_o(link_val_o),
    .dslot_o(dslot_o), .imm_o(imm_o), .resv_clr_o(resv_clr_o)
  );

  typedef struct packed {
    logic [4:0]  req;
    logic        ds, im, bi;
    logic [15:0] msr;
    logic [4:0]  ack;
    logic [31:0] npc;
    logic        lwe;
    logic [4:0]  lidx;
    logic [31:0] lval;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{5'b00001, 1'b0, 1'b0, 1'b0, 16'h2800, 5'b00001, 32'h8020, 1'b1, 5'd17, 32'h1000}, // R3 R4
    '{5'b00001, 1'b1, 1'b0, 1'b0, 16'h0000, 5'b00001, 32'h8020, 1'b1, 5'd17, 32'h0FFC}, // R5
    '{5'b00001, 1'b1, 1'b0, 1'b1, 16'h0000, 5'b00001, 32'h8020, 1'b1, 5'd17, 32'h0FF8}, // R5
    '{5'b00001, 1'b0, 1'b1, 1'b0, 16'h0000, 5'b00001, 32'h8020, 1'b1, 5'd17, 32'h0FFC}, // R5
    '{5'b00010, 1'b1, 1'b0, 1'b0, 16'h0000, 5'b00010, 32'h8020, 1'b1, 5'd17, 32'h1004}, // R4
    '{5'b00100, 1'b0, 1'b0, 1'b0, 16'h0000, 5'b00100, 32'h8018, 1'b1, 5'd16, 32'h1000}, // R3
    '{5'b01000, 1'b0, 1'b0, 1'b0, 16'h0000, 5'b01000, 32'h2000, 1'b0, 5'd0,  32'h0},    // R3 R4
    '{5'b10000, 1'b0, 1'b0, 1'b0, 16'h0002, 5'b10000, 32'h8010, 1'b1, 5'd14, 32'h1000}, // R3
    '{5'b11111, 1'b0, 1'b0, 1'b0, 16'h0002, 5'b00001, 32'h8020, 1'b1, 5'd17, 32'h1000}, // R1
    '{5'b11100, 1'b0, 1'b0, 1'b0, 16'h0002, 5'b00100, 32'h8018, 1'b1, 5'd16, 32'h1000}, // R1
    '{5'b11000, 1'b0, 1'b0, 1'b0, 16'h0002, 5'b01000, 32'h2000, 1'b0, 5'd0,  32'h0},    // R1
    '{5'b10000, 1'b0, 1'b0, 1'b0, 16'h0202, 5'b00000, 32'h0,    1'b0, 5'd0,  32'h0},    // R2
    '{5'b10000, 1'b1, 1'b0, 1'b0, 16'h0002, 5'b00000, 32'h0,    1'b0, 5'd0,  32'h0}     // R2
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [4:0] rq, input logic [31:0] st,
                      input logic [31:0] es, input logic ds, input logic im,
                      input logic bi, input logic en);
    @(negedge clk);
    req_i = rq; msr_i = st; esr_i = es; dslot_i = ds; imm_i = im;
    bimm_i = bi; exc_en_i = en; take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ack_o == 0 && pc_o == 0 && msr_o == 0 && link_we_o == 0 && resv_clr_o == 0,
        "R11 reset state", {27'd0, ack_o}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      fire(TBL[i].req, {16'h0, TBL[i].msr}, 32'h0, TBL[i].ds, TBL[i].im,
           TBL[i].bi, 1'b1);
      chk(ack_o == TBL[i].ack, $sformatf("R1 vec%0d ack", i), {27'd0, ack_o},
          {27'd0, TBL[i].ack});
      if (TBL[i].ack != 0)
        chk(pc_o == TBL[i].npc, $sformatf("R3 vec%0d pc", i), pc_o, TBL[i].npc);
      chk(link_we_o == TBL[i].lwe, $sformatf("R4 vec%0d link_we", i),
          {31'd0, link_we_o}, {31'd0, TBL[i].lwe});
      if (TBL[i].lwe) begin
        chk(link_idx_o == TBL[i].lidx, $sformatf("R4 vec%0d link_idx", i),
            {27'd0, link_idx_o}, {27'd0, TBL[i].lidx});
        chk(link_val_o == TBL[i].lval, $sformatf("R5 vec%0d link_val", i),
            link_val_o, TBL[i].lval);
      end
      chk(resv_clr_o == (TBL[i].ack != 0), $sformatf("R10 vec%0d resv", i),
          {31'd0, resv_clr_o}, {31'd0, TBL[i].ack != 0});
    end

    // R2 gate, combinational
    @(negedge clk);
    msr_i = 32'h2; dslot_i = 0; imm_i = 0; #1;
    chk(irq_ok_o == 1'b1, "R2 gate open", {31'd0, irq_ok_o}, 32'h1);
    msr_i = 32'h0A; #1;
    chk(irq_ok_o == 1'b0, "R2 gate bip", {31'd0, irq_ok_o}, 32'h0);
    msr_i = 32'h2; imm_i = 1; #1;
    chk(irq_ok_o == 1'b0, "R2 gate imm", {31'd0, irq_ok_o}, 32'h0);

    // R7 R8 status word updates
    fire(5'b00001, 32'h2800, 32'h0, 0, 0, 0, 1);
    chk(msr_o == 32'h5200, "R7 mmu status", msr_o, 32'h5200);
    fire(5'b10000, 32'h2802, 32'h0, 0, 0, 0, 1);
    chk(msr_o == 32'h5000, "R8 irq status", msr_o, 32'h5000);
    fire(5'b00100, 32'h0800, 32'h0, 0, 0, 0, 1);
    chk(msr_o == 32'h1008, "R7 hbrk status", msr_o, 32'h1008);
    fire(5'b01000, 32'h2000, 32'h0, 0, 0, 0, 1);
    chk(msr_o == 32'h4008, "R8 sbrk status", msr_o, 32'h4008);

    // R6 exception status and branch target
    fire(5'b00001, 32'h0, 32'hFFFF_FFFF, 0, 0, 0, 1);
    chk(esr_o == 32'hFFFF_EFFF, "R6 esr no dslot", esr_o, 32'hFFFF_EFFF);
    chk(btr_we_o == 0, "R6 btr_we quiet", {31'd0, btr_we_o}, 32'h0);
    fire(5'b00010, 32'h0, 32'h0, 1, 1, 0, 1);
    chk(esr_o == 32'h1000, "R6 esr dslot", esr_o, 32'h1000);
    chk(btr_we_o == 1 && btr_o == 32'h2000, "R6 btr load", btr_o, 32'h2000);
    chk(dslot_o == 0 && imm_o == 0, "R10 flags cleared",
        {30'd0, dslot_o, imm_o}, 32'h0);
    fire(5'b10000, 32'h2, 32'h1234, 0, 0, 0, 1);
    chk(esr_o == 32'h1234, "R6 irq esr kept", esr_o, 32'h1234);
    fire(5'b00100, 32'h0, 32'h0, 1, 0, 0, 1);
    chk(dslot_o == 1, "R10 break keeps dslot", {31'd0, dslot_o}, 32'h1);

    // R9 exception support disabled
    fire(5'b00110, 32'h0, 32'h0, 0, 0, 0, 0);
    chk(ack_o == 5'b00100, "R9 falls to hbrk", {27'd0, ack_o}, 32'h4);
    fire(5'b00010, 32'h0, 32'h0, 0, 0, 0, 0);
    chk(ack_o == 0 && pc_o == 32'h8018, "R9 ignored", pc_o, 32'h8018);

    // R11 no take
    @(negedge clk);
    req_i = 5'b00001; take_i = 0;
    @(negedge clk);
    chk(ack_o == 0 && resv_clr_o == 0 && pc_o == 32'h8018, "R11 no take",
        pc_o, 32'h8018);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule